// File: doc/BRIEF.md
# Cassette FSK Modem

This block sits between a UART and a cassette tape channel. On the transmit side it turns the UART's serial output bit into a square wave. Each pair of half-waves has a length set by the bit that was present when the high half began. A one gives the short half-wave (the higher tone). A zero gives the long half-wave (the lower tone). On the receive side it watches the already-digitized tape signal and measures the time from one rising edge to the next. It turns each such period into the bit that drives the UART's receive input.

All timing advances on a single-cycle sample tick, nominally 38400 per second. Three bit rates are supported: 300, 600 and 1200 bit/s. Each step up the rate ladder doubles both tones and halves the receive threshold. The block also produces the UART's bit-clock enable, a one-cycle pulse at sixteen times the selected bit rate. The rate is picked through a one-hot select input.

Top module: `cassette_fsk_modem`

## Requirements
- R1: After reset `tape_out` is 1, `uart_rxd` is 1 and `uart_clk_en` is 0. The rate is 300 bit/s, the current half-wave length is the 300 bit/s short length (8 ticks), the receive tick count is 0 and the last sampled tape level is 0.
- R2: `tape_out` inverts on the tick that ends the current half-wave, then holds for the full length of the next half-wave. A low half-wave reuses the length of the high half-wave just before it.
- R3: When `tape_out` goes high, `uart_txd` is sampled. A 1 selects 38400/(2·f1) ticks and a 0 selects 38400/(2·f0) ticks. Here f1 = 2400·2^k Hz and f0 = 1200·2^k Hz, with k = 0, 1, 2 for 300, 600, 1200 bit/s. This gives 8/16, 4/8 and 2/4 ticks.
- R4: Changes of `uart_txd` at any other time have no effect on the waveform.
- R5: The receiver counts ticks since the last rising edge, including the tick on which the edge is seen. The count saturates at its maximum. On a rising edge, `uart_rxd` becomes 1 if the count is below the threshold 38400/(1600·2^k) (24, 12 or 6) or above 32, and becomes 0 otherwise. The count then restarts at 0.
- R6: Only a 0-to-1 change of `tape_in` between two successive ticks is an edge. Falling edges and steady levels leave `uart_rxd` unchanged.
- R7: `uart_clk_en` is a one-cycle pulse on every 38400/(16·rate)-th tick (every 8, 4 or 2 ticks). It is registered, so it appears in the cycle after the tick.
- R8: `speed_sel` 3'b001 selects 300 bit/s, 3'b010 selects 600 bit/s and 3'b100 selects 1200 bit/s. The choice takes effect from the next clock. Any other value keeps the previous rate.
- R9: In clock cycles without `sample_tick`, no output or timing state changes, whatever `uart_txd` and `tape_in` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | One-cycle pulse per tape sample period |
| speed_sel | input | 3 | One-hot bit-rate select |
| uart_txd | input | 1 | Serial bit from the UART transmitter |
| tape_in | input | 1 | Digitized tape playback signal |
| tape_out | output | 1 | FSK square wave to the tape recorder |
| uart_rxd | output | 1 | Recovered serial bit to the UART receiver |
| uart_clk_en | output | 1 | UART bit-clock enable at 16× the bit rate |

## Verification
The bench sweeps the received period across each rate's threshold (one below, at, one above) and across the 32-tick long limit. A design that compared with <= instead of <, or that did not count the edge tick, would swap the decoded bit right at those boundaries. `uart_txd` is toggled at intervals unrelated to the wave period, so a modulator that sampled the bit on the falling half, or on every tick, would shorten or stretch half-waves away from the expected pattern. Invalid select codes, rate changes in mid-stream, a tick on every clock, and long stretches with no tick and moving inputs all check that the rate is held and that the timing state only moves on a tick.

// File: rtl/fsk_modem_pkg.sv
package fsk_modem_pkg;

  localparam int unsigned RATE_COUNT = 3;
  localparam int unsigned SEL_W      = RATE_COUNT;
  localparam int unsigned IDX_SLOTS  = 4;

  typedef logic [1:0] rate_idx_t;

  localparam rate_idx_t RATE_SLOW = 2'd0;

  // clamp a table slot onto a legal rate step
  function automatic int unsigned slot_to_step(input int unsigned slot);
    return (slot < RATE_COUNT) ? slot : RATE_COUNT - 1;
  endfunction

  function automatic int unsigned tone_at_rate(input int unsigned base_hz,
                                               input int unsigned step);
    return base_hz << step;
  endfunction

  function automatic int unsigned half_wave_ticks(input int unsigned tick_hz,
                                                  input int unsigned tone_hz);
    return tick_hz / (2 * tone_hz);
  endfunction

  function automatic int unsigned edge_threshold(input int unsigned tick_hz,
                                                 input int unsigned base_thr_hz,
                                                 input int unsigned step);
    return tick_hz / (base_thr_hz << step);
  endfunction

  function automatic int unsigned baud_divider(input int unsigned tick_hz,
                                               input int unsigned base_bps,
                                               input int unsigned oversample,
                                               input int unsigned step);
    return tick_hz / ((base_bps << step) * oversample);
  endfunction

endpackage

// File: rtl/fsk_rate_sel.sv
module fsk_rate_sel
  import fsk_modem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] speed_sel,
  output rate_idx_t        rate_idx
);

  logic      sel_valid;
  rate_idx_t sel_decoded;

  always_comb begin
    sel_valid   = 1'b0;
    sel_decoded = RATE_SLOW;
    for (int i = 0; i < RATE_COUNT; i++) begin
      if (speed_sel == SEL_W'(1 << i)) begin
        sel_valid   = 1'b1;
        sel_decoded = rate_idx_t'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rate_idx <= RATE_SLOW;
    else if (sel_valid) rate_idx <= sel_decoded;
  end

  // an invalid code must leave the rate where it was
  assert_rate_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |=> $stable(rate_idx));

  assert_rate_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |=> (rate_idx < RATE_COUNT));

endmodule

// File: rtl/fsk_modulator.sv
module fsk_modulator
  import fsk_modem_pkg::*;
#(
  parameter int unsigned TICK_HZ      = 38400,
  parameter int unsigned BASE_ONE_HZ  = 2400,
  parameter int unsigned BASE_ZERO_HZ = 1200,
  parameter int unsigned HW_W         = 8
)(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  rate_idx_t rate_idx,
  input  logic      tx_bit,
  output logic      wave_out
);

  localparam logic [HW_W-1:0] RESET_LEN = HW_W'(half_wave_ticks(TICK_HZ, BASE_ONE_HZ));

  logic [HW_W-1:0] short_tbl [IDX_SLOTS];
  logic [HW_W-1:0] long_tbl  [IDX_SLOTS];

  for (genvar g = 0; g < IDX_SLOTS; g++) begin : g_len
    assign short_tbl[g] = HW_W'(half_wave_ticks(TICK_HZ,
                            tone_at_rate(BASE_ONE_HZ, slot_to_step(g))));
    assign long_tbl[g]  = HW_W'(half_wave_ticks(TICK_HZ,
                            tone_at_rate(BASE_ZERO_HZ, slot_to_step(g))));
  end

  logic [HW_W-1:0] half_cnt;
  logic [HW_W-1:0] wave_len;
  logic [HW_W-1:0] pick_len;
  logic            wave_expire;
  logic            go_high;

  assign wave_expire = tick && (half_cnt <= HW_W'(1));
  assign go_high     = wave_expire && !wave_out;
  assign pick_len    = tx_bit ? short_tbl[rate_idx] : long_tbl[rate_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_out <= 1'b1;
      wave_len <= RESET_LEN;
      half_cnt <= RESET_LEN;
    end else if (wave_expire) begin
      wave_out <= !wave_out;
      if (go_high) begin
        wave_len <= pick_len;
        half_cnt <= pick_len;
      end else begin
        half_cnt <= wave_len;
      end
    end else if (tick) begin
      half_cnt <= half_cnt - HW_W'(1);
    end
  end

  assert_flip_on_expire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wave_expire |=> (wave_out != $past(wave_out)));

  assert_new_half_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go_high |=> (half_cnt == wave_len) && wave_out);

  assert_len_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !go_high |=> $stable(wave_len));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wave_out) && $stable(half_cnt));

endmodule

// File: rtl/fsk_demodulator.sv
module fsk_demodulator
  import fsk_modem_pkg::*;
#(
  parameter int unsigned TICK_HZ     = 38400,
  parameter int unsigned BASE_THR_HZ = 1600,
  parameter int unsigned LONG_LIMIT  = 32,
  parameter int unsigned LEN_W       = 8
)(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  rate_idx_t rate_idx,
  input  logic      line_in,
  output logic      rx_bit
);

  localparam logic [LEN_W-1:0] LONG_LIM = LEN_W'(LONG_LIMIT);

  logic [LEN_W-1:0] thr_tbl [IDX_SLOTS];

  for (genvar g = 0; g < IDX_SLOTS; g++) begin : g_thr
    assign thr_tbl[g] = LEN_W'(edge_threshold(TICK_HZ, BASE_THR_HZ, slot_to_step(g)));
  end

  logic             line_prev;
  logic [LEN_W-1:0] gap_len;
  logic [LEN_W-1:0] gap_next;
  logic             rise_evt;
  logic             bit_decision;

  assign gap_next     = (gap_len == '1) ? gap_len : gap_len + LEN_W'(1);
  assign rise_evt     = tick && line_in && !line_prev;
  assign bit_decision = (gap_next < thr_tbl[rate_idx]) || (gap_next > LONG_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_prev <= 1'b0;
      gap_len   <= '0;
      rx_bit    <= 1'b1;
    end else if (tick) begin
      line_prev <= line_in;
      if (rise_evt) begin
        gap_len <= '0;
        rx_bit  <= bit_decision;
      end else begin
        gap_len <= gap_next;
      end
    end
  end

  assert_gap_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> (gap_len == '0));

  assert_rx_on_edge_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> $stable(rx_bit));

  assert_gap_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(gap_len) && $stable(line_prev));

endmodule

// File: rtl/fsk_baud_gen.sv
module fsk_baud_gen
  import fsk_modem_pkg::*;
#(
  parameter int unsigned TICK_HZ    = 38400,
  parameter int unsigned BASE_BPS   = 300,
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned DIV_W      = 8
)(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  rate_idx_t rate_idx,
  output logic      baud_en
);

  logic [DIV_W-1:0] div_tbl [IDX_SLOTS];

  for (genvar g = 0; g < IDX_SLOTS; g++) begin : g_div
    assign div_tbl[g] = DIV_W'(baud_divider(TICK_HZ, BASE_BPS, OVERSAMPLE, slot_to_step(g)));
  end

  logic [DIV_W-1:0] div_cnt;
  logic             wrap;

  assign wrap = (div_cnt >= div_tbl[rate_idx] - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      baud_en <= 1'b0;
    end else if (tick) begin
      baud_en <= wrap;
      div_cnt <= wrap ? '0 : div_cnt + DIV_W'(1);
    end else begin
      baud_en <= 1'b0;
    end
  end

  assert_pulse_from_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    baud_en |-> $past(tick));

  assert_no_pulse_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !baud_en && $stable(div_cnt));

endmodule

// File: rtl/cassette_fsk_modem.sv
module cassette_fsk_modem
  import fsk_modem_pkg::*;
#(
  parameter int unsigned TICK_HZ      = 38400,
  parameter int unsigned BASE_BPS     = 300,
  parameter int unsigned BASE_ONE_HZ  = 2400,
  parameter int unsigned BASE_ZERO_HZ = 1200,
  parameter int unsigned BASE_THR_HZ  = 1600,
  parameter int unsigned LONG_LIMIT   = 32,
  parameter int unsigned OVERSAMPLE   = 16,
  parameter int unsigned HW_W         = 8,
  parameter int unsigned LEN_W        = 8,
  parameter int unsigned DIV_W        = 8
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic [2:0] speed_sel,
  input  logic       uart_txd,
  input  logic       tape_in,
  output logic       tape_out,
  output logic       uart_rxd,
  output logic       uart_clk_en
);

  rate_idx_t rate_idx;

  fsk_rate_sel u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .speed_sel (speed_sel),
    .rate_idx  (rate_idx)
  );

  fsk_modulator #(
    .TICK_HZ      (TICK_HZ),
    .BASE_ONE_HZ  (BASE_ONE_HZ),
    .BASE_ZERO_HZ (BASE_ZERO_HZ),
    .HW_W         (HW_W)
  ) u_mod (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sample_tick),
    .rate_idx (rate_idx),
    .tx_bit   (uart_txd),
    .wave_out (tape_out)
  );

  fsk_demodulator #(
    .TICK_HZ     (TICK_HZ),
    .BASE_THR_HZ (BASE_THR_HZ),
    .LONG_LIMIT  (LONG_LIMIT),
    .LEN_W       (LEN_W)
  ) u_demod (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sample_tick),
    .rate_idx (rate_idx),
    .line_in  (tape_in),
    .rx_bit   (uart_rxd)
  );

  fsk_baud_gen #(
    .TICK_HZ    (TICK_HZ),
    .BASE_BPS   (BASE_BPS),
    .OVERSAMPLE (OVERSAMPLE),
    .DIV_W      (DIV_W)
  ) u_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sample_tick),
    .rate_idx (rate_idx),
    .baud_en  (uart_clk_en)
  );

  // out of reset the line idles high and the receiver reports a one
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (tape_out && uart_rxd && !uart_clk_en) || rst_n);

endmodule

// File: tb/sim_cassette_fsk_modem.sv
module sim_cassette_fsk_modem;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0;
  logic [2:0] speed_sel = 3'b001;
  logic       uart_txd = 1'b1;
  logic       tape_in = 1'b0;
  wire        tape_out;
  wire        uart_rxd;
  wire        uart_clk_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  cassette_fsk_modem u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .speed_sel   (speed_sel),
    .uart_txd    (uart_txd),
    .tape_in     (tape_in),
    .tape_out    (tape_out),
    .uart_rxd    (uart_rxd),
    .uart_clk_en (uart_clk_en)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_r, m_lvl, m_wlen, m_cnt, m_dlen, m_bit, m_prev, m_bcnt, m_en;

  function automatic int t_short(int r); return 38400 / (2 * (2400 << r)); endfunction
  function automatic int t_long(int r);  return 38400 / (2 * (1200 << r)); endfunction
  function automatic int t_thr(int r);   return 38400 / (1600 << r);       endfunction
  function automatic int t_div(int r);   return 38400 / (16 * (300 << r)); endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r = 0; m_lvl = 1; m_wlen = t_short(0); m_cnt = t_short(0);
      m_dlen = 0; m_bit = 1; m_prev = 0; m_bcnt = 0; m_en = 0;
    end else begin
      if (sample_tick) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          if (m_lvl == 1) m_lvl = 0;
          else begin
            m_lvl = 1;
            m_wlen = uart_txd ? t_short(m_r) : t_long(m_r);
          end
          m_cnt = m_wlen;
        end
        if (m_dlen < 255) m_dlen = m_dlen + 1;
        if (tape_in && m_prev == 0) begin
          m_bit = (m_dlen < t_thr(m_r) || m_dlen > 32) ? 1 : 0;
          m_dlen = 0;
        end
        m_prev = tape_in ? 1 : 0;
        if (m_bcnt >= t_div(m_r) - 1) begin m_bcnt = 0; m_en = 1; end
        else begin m_bcnt = m_bcnt + 1; m_en = 0; end
      end else begin
        m_en = 0;
      end
      case (speed_sel)
        3'b001: m_r = 0;
        3'b010: m_r = 1;
        3'b100: m_r = 2;
        default: ;
      endcase
    end
  end

  // ---------------- stimulus driver and per-cycle compare ----------------
  int tper = 2, phase = 0;
  bit loopback = 1;
  int hi_t = 4, lo_t = 4, tcnt = 0;
  int txd_per = 0, txd_cnt = 0;
  bit compare_on = 0;

  always @(negedge clk) begin
    if (rst_n && compare_on) begin
      check("R2/R3/R4 tape_out", tape_out, m_lvl);
      check("R5/R6 uart_rxd", uart_rxd, m_bit);
      check("R7/R8 uart_clk_en", uart_clk_en, m_en);
    end
    if (tper == 0) sample_tick = 1'b0;
    else begin
      sample_tick = (phase == 0);
      phase = (phase + 1) % tper;
    end
    if (loopback) tape_in = tape_out;
    else if (sample_tick && tper != 0) begin
      tcnt++;
      if (tape_in && tcnt >= hi_t) begin tape_in = 1'b0; tcnt = 0; end
      else if (!tape_in && tcnt >= lo_t) begin tape_in = 1'b1; tcnt = 0; end
    end
    if (txd_per > 0) begin
      txd_cnt++;
      if (txd_cnt >= txd_per) begin uart_txd = ~uart_txd; txd_cnt = 0; end
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int plist[13] = '{5, 6, 7, 11, 12, 13, 23, 24, 25, 32, 33, 34, 40};
  logic s_out, s_rxd;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset tape_out", tape_out, 1);
    check("R1 reset uart_rxd", uart_rxd, 1);
    check("R1 reset uart_clk_en", uart_clk_en, 0);
    rst_n = 1'b1;
    compare_on = 1;

    // loopback at 300 bit/s, bit changes unrelated to wave timing (R3, R4)
    txd_per = 37;
    repeat (3000) @(negedge clk);
    txd_per = 0; uart_txd = 1'b0;
    repeat (600) @(negedge clk);
    uart_txd = 1'b1;
    repeat (600) @(negedge clk);

    // receive threshold sweep at every rate (R5, R6, R8)
    loopback = 0;
    for (int r = 0; r < 3; r++) begin
      speed_sel = 3'(1 << r);
      for (int i = 0; i < 13; i++) begin
        hi_t = plist[i] / 2;
        lo_t = plist[i] - hi_t;
        repeat (plist[i] * 2 * 4 + 10) @(negedge clk);
      end
    end

    // invalid select codes keep 1200 bit/s (R8)
    loopback = 1; txd_per = 11;
    foreach (plist[i]) begin end
    speed_sel = 3'b011; repeat (200) @(negedge clk);
    speed_sel = 3'b000; repeat (200) @(negedge clk);
    speed_sel = 3'b111; repeat (200) @(negedge clk);
    speed_sel = 3'b010; repeat (300) @(negedge clk);

    // tick on every clock, then every third clock
    tper = 1; repeat (600) @(negedge clk);
    tper = 3; speed_sel = 3'b001; repeat (900) @(negedge clk);

    // no ticks: inputs move, nothing changes (R9)
    tper = 0; loopback = 0; txd_per = 0;
    @(negedge clk);
    s_out = tape_out; s_rxd = uart_rxd;
    for (int k = 0; k < 40; k++) begin
      tape_in = k[0];
      uart_txd = k[1];
      @(negedge clk);
      check("R9 tape_out frozen", tape_out, s_out);
      check("R9 uart_rxd frozen", uart_rxd, s_rxd);
      check("R9 uart_clk_en idle", uart_clk_en, 0);
    end
    tper = 2; loopback = 1;
    repeat (400) @(negedge clk);

    // reset again mid-stream (R1)
    compare_on = 0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset tape_out", tape_out, 1);
    check("R1 re-reset uart_rxd", uart_rxd, 1);
    check("R1 re-reset uart_clk_en", uart_clk_en, 0);
    rst_n = 1'b1;
    compare_on = 1;
    repeat (500) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule